// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Transmitter

This block turns a stream of stereo PCM sample pairs into a single biphase-mark coded S/PDIF line. Each sample pair fills one frame. The frame has two 32-slot subframes: left audio goes in the first and right audio in the second. Frames are grouped into blocks of 192. The block inserts the three sync preambles, the validity, user, channel-status and parity slots, and codes every bit cell for the line.

The block runs from a single-cycle enable, `ui_en`, that pulses once per unit interval. That is twice the bit rate, for example 6.144 MHz at 48 kHz. The producer offers pairs through a valid/ready handshake into a one-pair holding register. The holding register is drained at the first unit interval of every frame. If no pair is waiting at that point, the block sends a silent frame marked invalid. A 192-bit channel-status vector supplies one C bit per frame.

Top module: `spdif_bmc_tx`

## Requirements
- R1: After reset the line output is low and `smp_ready` is high.
- R2: Each subframe lasts 64 unit intervals. The first 8 unit intervals carry a preamble. Preamble B starts the first subframe of frame 0 of a block. M starts every other first subframe, and W starts every second subframe. The patterns, listed first UI to last and taken with a low previous level, are B=11101000, M=11100010 and W=11100100. All eight levels are inverted when the line was high at the end of the previous cell.
- R3: Slots 4-31 are biphase-mark cells of two unit intervals each. The line inverts at the start of every cell and inverts again at mid-cell only for a 1. The line holds its level in every cycle where `ui_en` is low.
- R4: Slots 4-27 carry 24 audio bits, least significant bit first. The left sample goes in subframe A and the right sample in subframe B.
- R5: With SAMPLE_W below 24, each sample is left-aligned in slots 4-27, and the unused low slots are zero.
- R6: Slot 29 (U) is 0. Slot 30 (C) in both subframes of frame n carries bit n of `chan_status`.
- R7: Slot 31 (P) makes the count of ones in slots 4-31 of each subframe even.
- R8: `smp_ready` is high exactly when the holding register is empty. A pair taken with valid and ready drops `smp_ready` in the next cycle. That pair is sent in the next frame to start. While `smp_ready` is low, `smp_valid` has no effect on the data sent.
- R9: Slot 28 (V) is 0 for a frame built from a supplied pair. A frame that starts with no pair waiting carries zero audio in both subframes with V=1.
- R10: After frame 191 the frame index returns to 0, and the next block begins again with preamble B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ui_en | input | 1 | One-cycle pulse per unit interval |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register empty |
| smp_left | input | SAMPLE_W | Left sample |
| smp_right | input | SAMPLE_W | Right sample |
| chan_status | input | FRAMES | Channel-status bits, bit n used in frame n |
| spdif_out | output | 1 | Coded serial line |

## Verification
The line changes only at a clock edge where `ui_en` is high. The bench therefore pulses `ui_en` for one cycle and reads the line at the next falling edge, which gives exactly one level per unit interval. An accepted pair drops `smp_ready` after one edge. The pair first appears at the next frame's opening unit interval, with its audio LSB in unit intervals 8-9 of subframe A. For that reason the bench pushes each pair between frames and decodes every subframe from its 64 captured levels. The checks compare each captured frame, and the `smp_ready` level after a push, against values the bench computes from the requirements; they cover more than one full block.

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx #(
  parameter int SAMPLE_W = 24,
  parameter int FRAMES   = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ui_en,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [FRAMES-1:0]   chan_status,
  output logic                spdif_out
);
  localparam int AUD_W = 24;
  localparam int PAD   = AUD_W - SAMPLE_W;
  localparam int FR_W  = $clog2(FRAMES);
  localparam logic [7:0] PRE_B = 8'b1110_1000;
  localparam logic [7:0] PRE_M = 8'b1110_0010;
  localparam logic [7:0] PRE_W = 8'b1110_0100;

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                hold_full;
  logic [AUD_W-1:0]    cur_r;
  logic                cur_v;
  logic [5:0]          ui_cnt;
  logic                sub;
  logic [FR_W-1:0]     frame;
  logic [27:0]         sh;
  logic                inv, tx;

  logic [AUD_W-1:0] l_al, r_al, aud;
  logic             v_bit, c_bit, p_bit;
  logic [27:0]      word;
  logic [7:0]       pat;

  assign l_al  = AUD_W'(hold_l) << PAD;
  assign r_al  = AUD_W'(hold_r) << PAD;
  assign aud   = sub ? cur_r : (hold_full ? l_al : '0);
  assign v_bit = sub ? cur_v : ~hold_full;
  assign c_bit = chan_status[frame];
  assign p_bit = ^{aud, v_bit, c_bit};
  assign word  = {p_bit, c_bit, 1'b0, v_bit, aud};
  assign pat   = sub ? PRE_W : ((frame == '0) ? PRE_B : PRE_M);

  assign smp_ready = ~hold_full;
  assign spdif_out = tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l    <= '0;
      hold_r    <= '0;
      hold_full <= 1'b0;
      cur_r     <= '0;
      cur_v     <= 1'b0;
      ui_cnt    <= '0;
      sub       <= 1'b0;
      frame     <= '0;
      sh        <= '0;
      inv       <= 1'b0;
      tx        <= 1'b0;
    end else begin
      if (ui_en) begin
        ui_cnt <= ui_cnt + 6'd1;
        if (ui_cnt == 6'd63) begin
          sub <= ~sub;
          if (sub) frame <= (frame == FR_W'(FRAMES - 1)) ? '0 : frame + 1'b1;
        end
        if (ui_cnt == 6'd0) begin
          inv <= tx;
          tx  <= pat[7] ^ tx;
          sh  <= word;
          if (!sub) begin
            cur_r     <= hold_full ? r_al : '0;
            cur_v     <= ~hold_full;
            hold_full <= 1'b0;
          end
        end else if (ui_cnt < 6'd8) begin
          tx <= pat[3'd7 - ui_cnt[2:0]] ^ inv;
        end else if (!ui_cnt[0]) begin
          tx <= ~tx;
        end else begin
          tx <= tx ^ sh[0];
          sh <= sh >> 1;
        end
      end
      if (smp_valid && smp_ready) begin
        hold_l    <= smp_left;
        hold_r    <= smp_right;
        hold_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk #(
  parameter int FR_W   = 8,
  parameter int FRAMES = 192
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ui_en,
  input logic            smp_valid,
  input logic            smp_ready,
  input logic            spdif_out,
  input logic [5:0]      ui_cnt,
  input logic            sub,
  input logic [FR_W-1:0] frame
);
  p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready |=> !smp_ready);

  p_ready_waits_ui_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready && !ui_en |=> !smp_ready);

  p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ui_en |=> $stable(spdif_out));

  p_cell_start_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ui_en && ui_cnt >= 6'd8 && !ui_cnt[0] |=> spdif_out != $past(spdif_out));

  p_preamble_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ui_en && ui_cnt == 6'd0 |=> spdif_out != $past(spdif_out));

  p_block_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ui_en && ui_cnt == 6'd63 && sub && frame == FR_W'(FRAMES - 1) |=> frame == '0);
endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk #(.FR_W(FR_W), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ui_en(ui_en), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .spdif_out(spdif_out), .ui_cnt(ui_cnt),
  .sub(sub), .frame(frame));

// File: tb/spdif_bmc_tx_bench.sv
module spdif_bmc_tx_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, ui_en, smp_valid;
  logic [23:0]  smp_left, smp_right;
  logic [191:0] cs;
  logic         tx24, tx16, rdy24, rdy16;
  int checks = 0, errors = 0;

  localparam logic [7:0] PB = 8'b1110_1000;
  localparam logic [7:0] PM = 8'b1110_0010;
  localparam logic [7:0] PW = 8'b1110_0100;
  localparam logic [47:0] VEC [8] = '{
    {24'h000001, 24'h800000}, {24'hFFFFFF, 24'h000000},
    {24'h123456, 24'hABCDEF}, {24'h0000FF, 24'hFF0000},
    {24'h555555, 24'hAAAAAA}, {24'h7FFFFF, 24'h800001},
    {24'h00A500, 24'h5A005A}, {24'hC3C3C3, 24'h3C3C3C}};

  spdif_bmc_tx u_spdif_bmc_tx (.clk(clk), .rst_n(rst_n), .ui_en(ui_en),
    .smp_valid(smp_valid), .smp_ready(rdy24), .smp_left(smp_left),
    .smp_right(smp_right), .chan_status(cs), .spdif_out(tx24));

  spdif_bmc_tx #(.SAMPLE_W(16)) u_narrow (.clk(clk), .rst_n(rst_n), .ui_en(ui_en),
    .smp_valid(smp_valid), .smp_ready(rdy16), .smp_left(smp_left[23:8]),
    .smp_right(smp_right[23:8]), .chan_status(cs), .spdif_out(tx16));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(output logic a, output logic b);
    ui_en = 1'b1;
    @(negedge clk);
    ui_en = 1'b0;
    a = tx24;
    b = tx16;
    @(negedge clk);
  endtask

  task automatic push(input logic [47:0] pr);
    smp_valid = 1'b1;
    smp_left  = pr[47:24];
    smp_right = pr[23:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic check_sub(input logic [63:0] u, inout logic last,
                           input logic [7:0] pat, input string preq,
                           input logic [23:0] aud, input string areq,
                           input logic v, input logic c);
    logic [7:0]  got_p;
    logic [27:0] bits;
    logic        prev;
    bit          bp_ok;
    for (int i = 0; i < 8; i++) got_p[7-i] = u[i];
    chk(got_p == (pat ^ {8{last}}), preq, "preamble", int'(got_p), int'(pat ^ {8{last}}));
    prev  = u[7];
    bp_ok = 1'b1;
    for (int k = 0; k < 28; k++) begin
      if (u[8+2*k] == prev) bp_ok = 1'b0;
      bits[k] = u[8+2*k] ^ u[9+2*k];
      prev = u[9+2*k];
    end
    chk(bp_ok, "R3", "cell start inversion", int'(bp_ok), 1);
    chk(bits[23:0] == aud, areq, "audio slots", int'(bits[23:0]), int'(aud));
    chk(bits[24] == v, "R9", "validity", int'(bits[24]), int'(v));
    chk(bits[25] == 1'b0 && bits[26] == c, "R6", "user/status", int'(bits[26:25]), int'({c, 1'b0}));
    chk(^bits == 1'b0, "R7", "parity", int'(^bits), 0);
    last = u[63];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic l24, l16;
    rst_n = 1'b0; ui_en = 1'b0; smp_valid = 1'b0;
    smp_left = '0; smp_right = '0;
    for (int n = 0; n < 192; n++) cs[n] = (n % 3 == 0) || (n % 7 == 2);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx24 == 1'b0 && tx16 == 1'b0, "R1", "line after reset", int'({tx24, tx16}), 0);
    chk(rdy24 && rdy16, "R1", "ready after reset", int'({rdy24, rdy16}), 3);
    l24 = 1'b0;
    l16 = 1'b0;
    for (int f = 0; f < 193; f++) begin
      logic [47:0] pr;
      logic        skip;
      logic [23:0] el, er;
      logic [63:0] u24, u16;
      pr   = VEC[f % 8];
      skip = (f % 50 == 7);
      if (!skip) push(pr);
      if (f == 0) begin
        chk(!rdy24, "R8", "ready after accept", int'(rdy24), 0);
        smp_valid = 1'b1; smp_left = 24'hDEAD00; smp_right = 24'hBEEF00;
        repeat (3) @(negedge clk);
        smp_valid = 1'b0;
        chk(!rdy24 && !rdy16, "R8", "ready while held", int'({rdy24, rdy16}), 0);
      end
      el = skip ? 24'h0 : pr[47:24];
      er = skip ? 24'h0 : pr[23:0];
      for (int s = 0; s < 2; s++) begin
        logic [7:0] pat;
        for (int i = 0; i < 64; i++) begin
          logic a, b;
          step(a, b);
          u24[i] = a;
          u16[i] = b;
        end
        pat = (s == 1) ? PW : ((f % 192 == 0) ? PB : PM);
        check_sub(u24, l24, pat, (f == 192 && s == 0) ? "R10" : "R2",
                  (s == 0) ? el : er, "R4", skip, cs[f % 192]);
        check_sub(u16, l16, pat, "R2", ((s == 0) ? el : er) & 24'hFFFF00, "R5",
                  skip, cs[f % 192]);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule